// File: doc/BRIEF.md
# Prioritized Microtask Scheduler

This block lets one microsequencer serve sixteen fixed-priority tasks. It keeps a saved microinstruction address for each task and, whenever the running microcode issues its task-switch strobe, hands the sequencer to the highest-priority task whose hardware wakeup line is raised. Task 0 is the background interpreter, and its wakeup is treated as permanently raised.

The sequencer prefetches one microinstruction. In every cycle one instruction executes and the next one is read from `fetchAddr`. The NEXT field of the instruction being read, returned on `nextIn`, is ORed with the branch bits of the executing instruction and written back as the fetching task's saved address. As a result, a branch tested in one instruction steers the instruction that follows it. A task switch also takes effect one instruction late. The old task always executes the instruction it already prefetched, so `execTask` trails `curTask` by one cycle.

The BLOCK strobe only raises a one-hot line to the device that owns the executing task. Wakeups are never cleared here. Two TASK strobes in consecutive executed instructions are flagged as an error.

Top module: `utask_sched`

## Requirements
- R1: After reset `curTask` and `execTask` are 0 and every task's saved address equals its own task number. Task 0 fetches address 0 first, and the first fetch of task t after reset is address t.
- R2: `fetchAddr` is the saved address of `curTask`. On each unstalled cycle the saved address of `curTask` becomes `nextIn | branchIn`. For example, NEXT 0x042 with branch bit 0 set gives 0x043.
- R3: On an unstalled cycle with `taskFn` high, `curTask` is loaded at the clock edge with the highest-numbered raised bit of `wakeIn | 1`, where bit i of `wakeIn` is task i's wakeup.
- R4: On every unstalled edge `execTask` takes the old value of `curTask`, so the instruction prefetched before a switch still executes as the old task.
- R5: Without `taskFn`, `curTask` never changes, even when its own wakeup has dropped. With `taskFn` it stays put while its wakeup is raised and no higher one is, and it moves to a lower task only once its own wakeup is low.
- R6: A task's saved address is untouched while other tasks run, so returning to that task resumes exactly where it stopped.
- R7: `taskErr` is high in a cycle whose executing instruction has `taskFn` high, when the previous executed (unstalled) instruction also had `taskFn` high.
- R8: `blockOut` is one-hot at bit `execTask` when `blockFn` is high and `stall` is low, and all zero otherwise.
- R9: While `stall` is high the task registers and saved addresses hold, `fetchAddr` is unchanged, and `blockOut` and `taskErr` stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wakeIn | input | 16 | Wakeup line per task, bit i for task i |
| taskFn | input | 1 | Executing instruction requests a task switch |
| blockFn | input | 1 | Executing instruction issues BLOCK |
| branchIn | input | 12 | Branch bits of the executing instruction, ORed into the next address |
| nextIn | input | 12 | NEXT field of the instruction read from `fetchAddr` |
| stall | input | 1 | Freeze the scheduler for this cycle |
| fetchAddr | output | 12 | Microinstruction address being read |
| curTask | output | 4 | Task whose instructions are being fetched |
| execTask | output | 4 | Task owning the executing instruction |
| blockOut | output | 16 | One-hot BLOCK strobe to the executing task's device |
| taskErr | output | 1 | Consecutive TASK strobes detected |

## Verification
A directed run first walks a fixed scenario: a switch up from the background task, the prefetched old-task instruction issuing BLOCK, a branch-modified NEXT, a TASK that keeps the running task because its wakeup persists, a dropped wakeup that is ignored until TASK comes, and then a fall to a lower task and a return that must resume at the saved address. Stalls with every strobe raised show whether the freeze covers state and outputs. Back-to-back TASK strobes confirm the error flag. A long seeded random mix of wakeup vectors, strobes, branch bits and stalls is then compared each cycle with a reference model. The random wakeup vectors separate a correct priority encoder from a lowest-first or off-by-one one. The random branch bits expose an address path that drops or misroutes the OR.

// File: rtl/utask_sched_pkg.sv
package utask_sched_pkg;
  // Strobes passed from control to the address datapath.
  typedef struct packed {
    logic mpcWrite;   // commit new saved address for the fetching task
    logic holdAll;    // scheduler frozen this cycle
  } dpStrobes_t;
endpackage

// File: rtl/utask_sched_ctrl.sv
module utask_sched_ctrl
  import utask_sched_pkg::*;
#(
  parameter int NumTasks = 16,
  localparam int TaskW = $clog2(NumTasks)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [NumTasks-1:0] wakeIn,
  input  logic                taskFn,
  input  logic                blockFn,
  input  logic                stall,
  output logic [TaskW-1:0]    curTask,
  output logic [TaskW-1:0]    execTask,
  output logic [NumTasks-1:0] blockOut,
  output logic                taskErr,
  output dpStrobes_t          strobes
);

  logic [NumTasks-1:0] wakeEff;
  logic [TaskW-1:0]    winner;
  logic                lastWasTask;

  // Background task always requests service.
  assign wakeEff = wakeIn | NumTasks'(1);

  // Priority encoder: highest raised bit wins.
  always_comb begin
    winner = '0;
    for (int i = 0; i < NumTasks; i++) begin
      if (wakeEff[i]) winner = TaskW'(i);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curTask     <= '0;
      execTask    <= '0;
      lastWasTask <= 1'b0;
    end else if (!stall) begin
      execTask    <= curTask;
      lastWasTask <= taskFn;
      if (taskFn) curTask <= winner;
    end
  end

  assign taskErr = taskFn && lastWasTask && !stall;

  // One strobe line per task's device.
  for (genvar gi = 0; gi < NumTasks; gi++) begin : g_block
    assign blockOut[gi] = blockFn && !stall && (execTask == TaskW'(gi));
  end

  always_comb begin
    strobes.mpcWrite = !stall;
    strobes.holdAll  = stall;
  end

endmodule

// File: rtl/utask_sched_dp.sv
module utask_sched_dp
  import utask_sched_pkg::*;
#(
  parameter int NumTasks = 16,
  parameter int AddrW = 12,
  localparam int TaskW = $clog2(NumTasks)
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpStrobes_t       strobes,
  input  logic [TaskW-1:0] curTask,
  input  logic [AddrW-1:0] nextIn,
  input  logic [AddrW-1:0] branchIn,
  output logic [AddrW-1:0] fetchAddr
);

  logic [AddrW-1:0] mpcMem [NumTasks];
  logic [AddrW-1:0] newAddr;

  // Branch bits modify the NEXT of the already-fetched instruction.
  assign newAddr = nextIn | branchIn;

  for (genvar gi = 0; gi < NumTasks; gi++) begin : g_mpc
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        mpcMem[gi] <= AddrW'(gi);
      end else if (strobes.mpcWrite && !strobes.holdAll &&
                   curTask == TaskW'(gi)) begin
        mpcMem[gi] <= newAddr;
      end
    end
  end

  assign fetchAddr = mpcMem[curTask];

endmodule

// File: rtl/utask_sched.sv
module utask_sched
  import utask_sched_pkg::*;
#(
  parameter int NumTasks = 16,
  parameter int AddrW = 12,
  localparam int TaskW = $clog2(NumTasks)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [NumTasks-1:0] wakeIn,
  input  logic                taskFn,
  input  logic                blockFn,
  input  logic [AddrW-1:0]    branchIn,
  input  logic [AddrW-1:0]    nextIn,
  input  logic                stall,
  output logic [AddrW-1:0]    fetchAddr,
  output logic [TaskW-1:0]    curTask,
  output logic [TaskW-1:0]    execTask,
  output logic [NumTasks-1:0] blockOut,
  output logic                taskErr
);

  dpStrobes_t strobes;

  utask_sched_ctrl #(.NumTasks(NumTasks)) i_ctrl (
    .clk(clk), .rstN(rstN), .wakeIn(wakeIn), .taskFn(taskFn),
    .blockFn(blockFn), .stall(stall), .curTask(curTask),
    .execTask(execTask), .blockOut(blockOut), .taskErr(taskErr),
    .strobes(strobes)
  );

  utask_sched_dp #(.NumTasks(NumTasks), .AddrW(AddrW)) i_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .curTask(curTask),
    .nextIn(nextIn), .branchIn(branchIn), .fetchAddr(fetchAddr)
  );

endmodule

// File: rtl/utask_sched_chk.sv
module utask_sched_chk #(
  parameter int NumTasks = 16,
  parameter int AddrW = 12,
  localparam int TaskW = $clog2(NumTasks)
) (
  input logic                clk,
  input logic                rstN,
  input logic [NumTasks-1:0] wakeIn,
  input logic                taskFn,
  input logic                blockFn,
  input logic [AddrW-1:0]    branchIn,
  input logic [AddrW-1:0]    nextIn,
  input logic                stall,
  input logic [AddrW-1:0]    fetchAddr,
  input logic [TaskW-1:0]    curTask,
  input logic [TaskW-1:0]    execTask,
  input logic [NumTasks-1:0] blockOut,
  input logic                taskErr
);

  logic [NumTasks-1:0] wakeEff;
  assign wakeEff = wakeIn | NumTasks'(1);

  a_r3_switch_to_top: assert property (@(posedge clk) disable iff (!rstN)
    (!stall && taskFn) |=> (($past(wakeEff) >> curTask) == NumTasks'(1)));

  a_r5_no_task_no_move: assert property (@(posedge clk) disable iff (!rstN)
    (!stall && !taskFn) |=> $stable(curTask));

  a_r4_exec_lags: assert property (@(posedge clk) disable iff (!rstN)
    !stall |=> execTask == $past(curTask));

  a_r2_next_or_branch: assert property (@(posedge clk) disable iff (!rstN)
    (!stall && !taskFn) |=> fetchAddr == $past(nextIn | branchIn));

  a_r9_stall_hold: assert property (@(posedge clk) disable iff (!rstN)
    stall |=> ($stable(curTask) && $stable(execTask) && $stable(fetchAddr)));

  a_r8_block_onehot: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(blockOut) && ((blockOut != '0) -> (blockFn && !stall)));

  a_r7_err_needs_task: assert property (@(posedge clk) disable iff (!rstN)
    taskErr |-> (taskFn && !stall));

endmodule

bind utask_sched utask_sched_chk #(.NumTasks(NumTasks), .AddrW(AddrW)) i_chk (
  .clk(clk), .rstN(rstN), .wakeIn(wakeIn), .taskFn(taskFn),
  .blockFn(blockFn), .branchIn(branchIn), .nextIn(nextIn), .stall(stall),
  .fetchAddr(fetchAddr), .curTask(curTask), .execTask(execTask),
  .blockOut(blockOut), .taskErr(taskErr)
);

// File: tb/test_utask_sched.sv
module test_utask_sched;
  localparam int NT = 16;
  localparam int AW = 12;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [NT-1:0] wakeIn = '0;
  logic          taskFn = 1'b0, blockFn = 1'b0, stall = 1'b0;
  logic [AW-1:0] branchIn = '0, nextIn = '0;
  logic [AW-1:0] fetchAddr;
  logic [3:0]    curTask, execTask;
  logic [NT-1:0] blockOut;
  logic          taskErr;

  int errors = 0;
  int checks = 0;
  int cycles = 0;
  bit done = 0;

  // Reference state
  logic [AW-1:0] refMpc [NT];
  logic [3:0]    refCur, refExec;
  bit            refLastTask;

  always #2.5 clk = ~clk;

  utask_sched i_utask_sched (
    .clk(clk), .rstN(rstN), .wakeIn(wakeIn), .taskFn(taskFn),
    .blockFn(blockFn), .branchIn(branchIn), .nextIn(nextIn), .stall(stall),
    .fetchAddr(fetchAddr), .curTask(curTask), .execTask(execTask),
    .blockOut(blockOut), .taskErr(taskErr)
  );

  function automatic logic [3:0] topTask(input logic [NT-1:0] w);
    logic [3:0] r = 4'd0;
    for (int i = 0; i < NT; i++) if (w[i] || i == 0) r = 4'(i);
    return r;
  endfunction

  task automatic chk(input string tag, input longint got, input longint exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic modelReset();
    for (int t = 0; t < NT; t++) refMpc[t] = AW'(t);
    refCur = 0; refExec = 0; refLastTask = 0;
  endtask

  // One cycle: drive, check combinational outputs, clock, check registers.
  task automatic step(input logic [NT-1:0] w, input bit tf, input bit bf,
                      input logic [AW-1:0] nx, input logic [AW-1:0] br,
                      input bit st);
    logic [NT-1:0] expBlk;
    @(negedge clk);
    wakeIn = w; taskFn = tf; blockFn = bf; nextIn = nx; branchIn = br; stall = st;
    #1;
    expBlk = (bf && !st) ? (NT'(1) << refExec) : '0;
    chk("R2 fetchAddr", fetchAddr, refMpc[refCur]);
    chk("R8 blockOut", blockOut, expBlk);
    chk("R7 taskErr", taskErr, tf && refLastTask && !st);
    if (!st) begin
      refMpc[refCur] = nx | br;
      refExec = refCur;
      refLastTask = tf;
      if (tf) refCur = topTask(w);
    end
    @(posedge clk);
    #1;
    chk("R3 curTask", curTask, refCur);
    chk("R4 execTask", execTask, refExec);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      errors++; checks++;
      $display("FAIL watchdog: got %0d cycles expected below 100000", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [AW-1:0] heldAddr;
    void'($urandom(32'd4711));
    modelReset();
    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1'b1;
    #1;
    chk("R1 reset curTask", curTask, 0);
    chk("R1 reset execTask", execTask, 0);
    chk("R1 reset fetchAddr", fetchAddr, 0);

    // Switch up from background to task 5.
    step(16'h0020, 1, 0, 12'h100, 12'h000, 0);
    chk("R3 switch to 5", curTask, 5);
    chk("R1 first fetch of task 5", fetchAddr, 5);
    chk("R4 prefetched old task", execTask, 0);
    // Old task's prefetched instruction issues BLOCK.
    step(16'h0020, 0, 1, 12'h041, 12'h000, 0);
    chk("R4 exec now 5", execTask, 5);
    // Branch bit ORed into NEXT.
    step(16'h0020, 0, 0, 12'h042, 12'h001, 0);
    chk("R2 branch 042|1", fetchAddr, 12'h043);
    // Own wakeup held plus lower pending: stay.
    step(16'h0028, 1, 0, 12'h050, 12'h000, 0);
    chk("R5 stays on 5", curTask, 5);
    // Consecutive TASK: error flag.
    @(negedge clk); wakeIn = 16'h0028; taskFn = 1; #1;
    chk("R7 back-to-back TASK", taskErr, 1);
    step(16'h0028, 1, 0, 12'h058, 12'h000, 0);
    // Own wakeup dropped, no TASK: no move.
    step(16'h0008, 0, 0, 12'h060, 12'h000, 0);
    chk("R5 no move without TASK", curTask, 5);
    step(16'h0008, 1, 0, 12'h070, 12'h000, 0);
    chk("R5 fall to lower task 3", curTask, 3);
    chk("R1 first fetch of task 3", fetchAddr, 3);
    // Stall with every strobe raised.
    heldAddr = fetchAddr;
    @(negedge clk); taskFn = 1; blockFn = 1; stall = 1; wakeIn = 16'hFFFF; #1;
    chk("R9 no block in stall", blockOut, 0);
    chk("R9 no err in stall", taskErr, 0);
    step(16'hFFFF, 1, 1, 12'h0AA, 12'h000, 1);
    chk("R9 task held", curTask, 3);
    chk("R9 address held", fetchAddr, heldAddr);
    // Return to 5: resume at saved address.
    step(16'h0020, 1, 0, 12'h080, 12'h000, 0);
    chk("R6 resume task 5", fetchAddr, 12'h070);

    for (int n = 0; n < 3000; n++) begin
      logic [NT-1:0] w;
      w = NT'($urandom) & NT'($urandom);
      step(w, ($urandom % 4) == 0, ($urandom % 3) == 0, AW'($urandom),
           AW'($urandom % 4), ($urandom % 8) == 0);
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule